// File: doc/BRIEF.md
# PMP Configuration Register Bank

This block is the storage side of a physical memory protection unit. It keeps one configuration byte and one address register per protection entry, plus a small machine security register, and serves indexed control-register reads and writes from the hart. A configuration control register packs several entry bytes: each byte of a write is judged and stored (or refused) on its own. Region bound computation and access checking live in neighbouring blocks, which take the stored values from the flat output buses.

Writes are filtered by the protection rules. An entry with its lock bit set is frozen. A lock-bypass bit in the security register lifts that freeze. A lockdown mode replaces the lock test with a test on the value being written. An address register is also frozen while its successor is a locked top-of-range entry. The two lockdown bits can only be set, never cleared, until reset. The block keeps a count of entries whose match mode is not OFF. It pulses a flush output when a write really changes protection state.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset, every configuration byte, every address register and all three security bits are zero, `rule_count` is 0 and `flush` is low.
- R2: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock. A configuration write (`wr_kind`=0) at index k sends data byte i (bits 8i+7:8i) to entry 4k+i, for i below XLEN/8. A configuration read returns the same packing.
- R3: With lockdown clear and bypass clear, a configuration write to an entry whose lock bit is set leaves that byte unchanged.
- R4: An address write (`wr_kind`=1) to entry e is dropped when entry e is locked. It is also dropped when entry e+1 is locked with match mode top-of-range.
- R5: With the bypass bit set, no entry counts as locked, so writes covered by R3 and R4 are stored.
- R6: With lockdown set, a configuration byte is stored if its new value has the lock bit set and execute clear, or has the lock bit clear and bits 2:0 not equal to 3'b110; otherwise it is refused, whatever the entry's current lock bit.
- R7: Security register (`wr_kind`=2) bit 0 is lockdown, bit 1 is machine whitelist, bit 2 is bypass. Bypass cannot go from 0 to 1 while any entry has its lock bit set; it can always be cleared.
- R8: Once lockdown or whitelist is 1, it stays 1 until reset whatever is written.
- R9: Writes naming an entry at or beyond the entry count change nothing. Reads of such entries return zero in the affected bytes.
- R10: `rule_count` equals the number of entries whose match mode is not 0, and changes on the same edge as the configuration.
- R11: `flush` is high for exactly the cycle after a write edge that changed a stored configuration byte, an address register, lockdown or whitelist. It stays low for writes that store the same value or are refused.
- R12: A read (`rd_en`) returns data in `rd_data` one edge later, taken from the state before any write on that same edge. `rd_data` holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write target: 0 configuration, 1 address, 2 security, 3 none |
| wr_idx | input | IDX_W | Write index (packed register or entry) |
| wr_data | input | XLEN | Write data |
| rd_en | input | 1 | Read strobe |
| rd_kind | input | 2 | Read target, same encoding as wr_kind |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | XLEN | Registered read data |
| cfg_flat | output | 8*N_ENTRIES | All configuration bytes, entry e at bits 8e+7:8e |
| addr_flat | output | XLEN*N_ENTRIES | All address registers, entry e at slice e |
| sec_state | output | 3 | {bypass, whitelist, lockdown} |
| rule_count | output | CW | Number of entries with match mode not off |
| flush | output | 1 | One-cycle pulse on an effective protection change |

## Verification
The hardest cases to reach are the refusals that depend on a neighbour or on history. These are an address write blocked only because the next entry is a locked top-of-range entry, and a bypass request refused because a lock already exists. Reaching them needs a locked entry first. Locked entries and the sticky lockdown bits cannot be undone by writes, so the stimulus resets the block between the plain-lock, bypass and lockdown phases. Each phase builds its lock with one packed write and then probes refused and accepted bytes in the same word. A behavioural model in the bench follows every edge, and directed read-backs confirm each case.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csr_kind_e;

  localparam int unsigned CFG_BIT_X    = 2;
  localparam int unsigned CFG_BIT_LOCK = 7;
  localparam logic [1:0]  MATCH_OFF    = 2'd0;
  localparam logic [1:0]  MATCH_TOR    = 2'd1;

  localparam int unsigned SEC_LOCKDOWN  = 0;
  localparam int unsigned SEC_WHITELIST = 1;
  localparam int unsigned SEC_BYPASS    = 2;

  // entries per packed configuration register index step
  localparam int unsigned CFG_STRIDE = 4;

  function automatic logic [1:0] match_mode(input logic [7:0] cfg);
    return cfg[4:3];
  endfunction

  // value-based acceptance used while lockdown is active
  function automatic logic lockdown_accepts(input logic [7:0] v);
    return (v[CFG_BIT_LOCK] && !v[CFG_BIT_X]) ||
           (!v[CFG_BIT_LOCK] && (v[2:0] != 3'b110));
  endfunction

endpackage

// File: rtl/pmp_entry.sv
module pmp_entry
  import pmp_bank_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  input  logic          bypass,
  input  logic          lockdown,
  input  logic          next_lock_tor,
  output logic [7:0]    cfg_q,
  output logic [7:0]    cfg_nxt,
  output logic [AW-1:0] addr_q,
  output logic          lock_raw,
  output logic          lock_tor,
  output logic          changed
);

  logic locked;
  logic cfg_ok;
  logic addr_ok;
  logic cfg_chg;
  logic addr_chg;

  assign locked = cfg_q[CFG_BIT_LOCK] & ~bypass;

  always_comb begin
    cfg_ok   = bypass | (lockdown ? lockdown_accepts(cfg_wdata) : ~locked);
    addr_ok  = ~locked & ~next_lock_tor;
    cfg_chg  = cfg_we & cfg_ok & (cfg_wdata != cfg_q);
    addr_chg = addr_we & addr_ok & (addr_wdata != addr_q);
    cfg_nxt  = cfg_chg ? cfg_wdata : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_chg)  cfg_q  <= cfg_wdata;
      if (addr_chg) addr_q <= addr_wdata;
    end
  end

  assign lock_raw = cfg_q[CFG_BIT_LOCK];
  assign lock_tor = locked & (match_mode(cfg_q) == MATCH_TOR);
  assign changed  = cfg_chg | addr_chg;

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[CFG_BIT_LOCK] && !bypass && !lockdown) |=> $stable(cfg_q));

  // R4
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_q[CFG_BIT_LOCK] && !bypass) || next_lock_tor) |=> $stable(addr_q));

endmodule

// File: rtl/pmp_sec_ctl.sv
module pmp_sec_ctl
  import pmp_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] wdata,
  input  logic       any_lock_raw,
  output logic       lockdown,
  output logic       whitelist,
  output logic       bypass,
  output logic       changed
);

  logic lockdown_n;
  logic whitelist_n;
  logic bypass_n;

  always_comb begin
    lockdown_n  = lockdown;
    whitelist_n = whitelist;
    bypass_n    = bypass;
    if (we) begin
      lockdown_n  = lockdown  | wdata[SEC_LOCKDOWN];
      whitelist_n = whitelist | wdata[SEC_WHITELIST];
      bypass_n    = wdata[SEC_BYPASS] & (bypass | ~any_lock_raw);
    end
  end

  assign changed = (lockdown_n != lockdown) | (whitelist_n != whitelist);

  always_ff @(posedge clk) begin
    if (rst) begin
      lockdown  <= 1'b0;
      whitelist <= 1'b0;
      bypass    <= 1'b0;
    end else begin
      lockdown  <= lockdown_n;
      whitelist <= whitelist_n;
      bypass    <= bypass_n;
    end
  end

  // R8
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lockdown |=> lockdown);

  // R8
  whitelist_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    whitelist |=> whitelist);

  // R7
  bypass_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!bypass && any_lock_raw) |=> !bypass);

endmodule

// File: rtl/pmp_rule_counter.sv
module pmp_rule_counter
  import pmp_bank_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned CW = $clog2(N_ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [8*N_ENTRIES-1:0] cfg_nxt_flat,
  output logic [CW-1:0]          count_q
);

  logic [CW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int e = 0; e < int'(N_ENTRIES); e++) begin
      if (match_mode(cfg_nxt_flat[8*e +: 8]) != MATCH_OFF) sum = sum + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= sum;
  end

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(N_ENTRIES));

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_bank_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IDX_W     = 6,
  localparam int unsigned BPC      = XLEN / 8,
  localparam int unsigned CW       = $clog2(N_ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_kind,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [XLEN-1:0]           wr_data,
  input  logic                      rd_en,
  input  logic [1:0]                rd_kind,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [XLEN-1:0]           rd_data,
  output logic [8*N_ENTRIES-1:0]    cfg_flat,
  output logic [XLEN*N_ENTRIES-1:0] addr_flat,
  output logic [2:0]                sec_state,
  output logic [CW-1:0]             rule_count,
  output logic                      flush
);

  logic [7:0]      cfg_arr  [N_ENTRIES];
  logic [XLEN-1:0] addr_arr [N_ENTRIES];
  logic [7:0]      cfg_wb   [N_ENTRIES];
  logic [N_ENTRIES-1:0] cfg_we;
  logic [N_ENTRIES-1:0] addr_we;
  logic [N_ENTRIES-1:0] lock_raw;
  logic [N_ENTRIES-1:0] lock_tor;
  logic [N_ENTRIES-1:0] next_lock_tor;
  logic [N_ENTRIES-1:0] entry_chg;
  logic [8*N_ENTRIES-1:0] cfg_nxt_flat;

  logic lockdown;
  logic whitelist;
  logic bypass;
  logic sec_chg;
  logic sec_we;
  logic [XLEN-1:0] rd_val;

  // write decode: packed configuration bytes fan out to entries
  always_comb begin
    for (int e = 0; e < int'(N_ENTRIES); e++) begin
      cfg_we[e]  = 1'b0;
      cfg_wb[e]  = '0;
      for (int i = 0; i < int'(BPC); i++) begin
        if (wr_en && wr_kind == KIND_CFG &&
            int'(wr_idx) * int'(CFG_STRIDE) + i == e) begin
          cfg_we[e] = 1'b1;
          cfg_wb[e] = wr_data[8*i +: 8];
        end
      end
      addr_we[e] = wr_en && wr_kind == KIND_ADDR && int'(wr_idx) == e;
    end
  end

  assign sec_we = wr_en && wr_kind == KIND_SEC;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    if (g + 1 < N_ENTRIES) begin : g_nxt
      assign next_lock_tor[g] = lock_tor[g+1];
    end else begin : g_last
      assign next_lock_tor[g] = 1'b0;
    end

    pmp_entry #(.AW(XLEN)) u_entry (
      .clk           (clk),
      .rst           (rst),
      .cfg_we        (cfg_we[g]),
      .cfg_wdata     (cfg_wb[g]),
      .addr_we       (addr_we[g]),
      .addr_wdata    (wr_data),
      .bypass        (bypass),
      .lockdown      (lockdown),
      .next_lock_tor (next_lock_tor[g]),
      .cfg_q         (cfg_arr[g]),
      .cfg_nxt       (cfg_nxt_flat[8*g +: 8]),
      .addr_q        (addr_arr[g]),
      .lock_raw      (lock_raw[g]),
      .lock_tor      (lock_tor[g]),
      .changed       (entry_chg[g])
    );

    assign cfg_flat[8*g +: 8]        = cfg_arr[g];
    assign addr_flat[XLEN*g +: XLEN] = addr_arr[g];
  end

  pmp_sec_ctl u_sec (
    .clk          (clk),
    .rst          (rst),
    .we           (sec_we),
    .wdata        (wr_data[2:0]),
    .any_lock_raw (|lock_raw),
    .lockdown     (lockdown),
    .whitelist    (whitelist),
    .bypass       (bypass),
    .changed      (sec_chg)
  );

  pmp_rule_counter #(.N_ENTRIES(N_ENTRIES)) u_count (
    .clk          (clk),
    .rst          (rst),
    .cfg_nxt_flat (cfg_nxt_flat),
    .count_q      (rule_count)
  );

  assign sec_state = {bypass, whitelist, lockdown};

  // read mux over pre-edge state
  always_comb begin
    rd_val = '0;
    case (rd_kind)
      KIND_CFG: begin
        for (int e = 0; e < int'(N_ENTRIES); e++) begin
          for (int i = 0; i < int'(BPC); i++) begin
            if (int'(rd_idx) * int'(CFG_STRIDE) + i == e) rd_val[8*i +: 8] = cfg_arr[e];
          end
        end
      end
      KIND_ADDR: begin
        for (int e = 0; e < int'(N_ENTRIES); e++) begin
          if (int'(rd_idx) == e) rd_val = addr_arr[e];
        end
      end
      KIND_SEC: begin
        rd_val[SEC_LOCKDOWN]  = lockdown;
        rd_val[SEC_WHITELIST] = whitelist;
        rd_val[SEC_BYPASS]    = bypass;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      flush   <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_val;
      flush <= (|entry_chg) | sec_chg;
    end
  end

  // R11
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(wr_en));

  // R11
  flush_single_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !$past(wr_en, 1)) |-> 1'b0);

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_pmp_csr_bank.sv
module tb_pmp_csr_bank;
  localparam int N  = 16;
  localparam int XL = 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_kind = 2'd3, rd_kind = 2'd3;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [XL-1:0] wr_data = '0;
  logic [XL-1:0] rd_data;
  logic [8*N-1:0] cfg_flat;
  logic [XL*N-1:0] addr_flat;
  logic [2:0] sec_state;
  logic [4:0] rule_count;
  logic flush;

  pmp_csr_bank #(.N_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_en(rd_en), .rd_kind(rd_kind), .rd_idx(rd_idx),
    .rd_data(rd_data), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
    .sec_state(sec_state), .rule_count(rule_count), .flush(flush)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [7:0]  m_cfg  [N];
  logic [31:0] m_addr [N];
  bit m_ld, m_wl, m_bp, m_flush;
  logic [31:0] m_rd;
  int m_cnt;

  function automatic bit m_frozen(int e);
    return m_cfg[e][7] && !m_bp;
  endfunction

  always @(posedge clk) begin : model
    logic [7:0] ncfg [N];
    logic [31:0] naddr [N];
    bit chg, nld, nwl, nbp, anyl;
    if (rst) begin
      for (int e = 0; e < N; e++) begin m_cfg[e] = 0; m_addr[e] = 0; end
      m_ld = 0; m_wl = 0; m_bp = 0; m_flush = 0; m_rd = 0; m_cnt = 0;
    end else begin
      chg = 0;
      for (int e = 0; e < N; e++) begin ncfg[e] = m_cfg[e]; naddr[e] = m_addr[e]; end
      nld = m_ld; nwl = m_wl; nbp = m_bp;
      if (rd_en) begin
        m_rd = 0;
        if (rd_kind == 0)
          for (int i = 0; i < 4; i++) begin
            if (int'(rd_idx) * 4 + i < N) m_rd[8*i +: 8] = m_cfg[int'(rd_idx) * 4 + i];
          end
        else if (rd_kind == 1) begin
          if (int'(rd_idx) < N) m_rd = m_addr[int'(rd_idx)];
        end else if (rd_kind == 2) m_rd = {29'd0, m_bp, m_wl, m_ld};
      end
      if (wr_en && wr_kind == 0) begin
        for (int i = 0; i < 4; i++) begin
          int e;
          logic [7:0] v;
          bit ok;
          e = int'(wr_idx) * 4 + i;
          v = wr_data[8*i +: 8];
          if (e < N) begin
            if (m_bp) ok = 1;
            else if (m_ld) ok = (v[7] && !v[2]) || (!v[7] && v[2:0] != 3'b110);
            else ok = !m_cfg[e][7];
            if (ok && v != m_cfg[e]) begin ncfg[e] = v; chg = 1; end
          end
        end
      end
      if (wr_en && wr_kind == 1 && int'(wr_idx) < N) begin
        int e;
        bit blocked;
        e = int'(wr_idx);
        blocked = m_frozen(e);
        if (e + 1 < N && m_frozen(e + 1) && m_cfg[e+1][4:3] == 2'd1) blocked = 1;
        if (!blocked && wr_data != m_addr[e]) begin naddr[e] = wr_data; chg = 1; end
      end
      if (wr_en && wr_kind == 2) begin
        anyl = 0;
        for (int e = 0; e < N; e++) if (m_cfg[e][7]) anyl = 1;
        nld = m_ld || wr_data[0];
        nwl = m_wl || wr_data[1];
        nbp = wr_data[2] && (m_bp || !anyl);
        if (nld != m_ld || nwl != m_wl) chg = 1;
      end
      m_cnt = 0;
      for (int e = 0; e < N; e++) begin
        m_cfg[e] = ncfg[e]; m_addr[e] = naddr[e];
        if (ncfg[e][4:3] != 0) m_cnt++;
      end
      m_ld = nld; m_wl = nwl; m_bp = nbp; m_flush = chg;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ok;
      ok = (rule_count == 5'(m_cnt)) && (flush == m_flush) && (rd_data == m_rd) &&
           (sec_state == {m_bp, m_wl, m_ld});
      for (int e = 0; e < N; e++) begin
        if (cfg_flat[8*e +: 8] != m_cfg[e]) ok = 0;
        if (addr_flat[32*e +: 32] != m_addr[e]) ok = 0;
      end
      chk("model compare R3 R4 R10 R11", {63'd0, ok}, 64'd1);
    end
  end

  task automatic wr(input logic [1:0] k, input int idx, input logic [31:0] d);
    wr_en = 1; wr_kind = k; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_kind = 2'd3;
  endtask

  task automatic rd(input logic [1:0] k, input int idx, output logic [31:0] v);
    rd_en = 1; rd_kind = k; rd_idx = IW'(idx);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 cfg after reset", 64'(cfg_flat[63:0]), 64'd0);
    chk("R1 count after reset", 64'(rule_count), 64'd0);
    chk("R1 flush after reset", 64'(flush), 64'd0);
    rd(2'd2, 0, v); chk("R1 security after reset", 64'(v), 64'd0);

    // R2 packing, R10 count, R11 flush
    wr(2'd0, 0, 32'h11190B00);
    chk("R11 flush on cfg change", 64'(flush), 64'd1);
    chk("R10 count three active", 64'(rule_count), 64'd3);
    chk("R2 entry2 byte on flat bus", 64'(cfg_flat[23:16]), 64'h19);
    rd(2'd0, 0, v); chk("R2 packed cfg read", 64'(v), 64'h11190B00);
    wr(2'd0, 0, 32'h11190B00);
    chk("R11 no flush on same value", 64'(flush), 64'd0);
    wr(2'd1, 0, 32'h1000);
    rd(2'd1, 0, v); chk("R2 addr read back", 64'(v), 64'h1000);

    // R3, R4 with entry1 locked top-of-range
    wr(2'd0, 0, 32'h11198900);
    wr(2'd1, 0, 32'h2000);
    chk("R4 no flush on blocked addr", 64'(flush), 64'd0);
    rd(2'd1, 0, v); chk("R4 addr blocked by locked TOR successor", 64'(v), 64'h1000);
    wr(2'd1, 1, 32'h3000);
    rd(2'd1, 1, v); chk("R4 addr of locked entry", 64'(v), 64'h0);
    wr(2'd1, 2, 32'h40);
    rd(2'd1, 2, v); chk("R4 unblocked addr stored", 64'(v), 64'h40);
    wr(2'd0, 0, 32'h11190000);
    rd(2'd0, 0, v); chk("R3 locked byte kept", 64'(v), 64'h11198900);
    wr(2'd2, 0, 32'h4);
    rd(2'd2, 0, v); chk("R7 bypass refused under lock", 64'(v), 64'h0);

    // R12 same-edge read sees old value
    wr_en = 1; wr_kind = 2'd1; wr_idx = 6'd2; wr_data = 32'h80;
    rd_en = 1; rd_kind = 2'd1; rd_idx = 6'd2;
    @(negedge clk);
    wr_en = 0; rd_en = 0; wr_kind = 2'd3;
    chk("R12 read returns pre-write value", 64'(rd_data), 64'h40);
    @(negedge clk);
    chk("R12 rd_data holds", 64'(rd_data), 64'h40);
    rd(2'd1, 2, v); chk("R12 new value after edge", 64'(v), 64'h80);

    // R9 out of range
    wr(2'd0, 4, 32'hFFFFFFFF);
    chk("R9 no flush out of range cfg", 64'(flush), 64'd0);
    rd(2'd0, 4, v); chk("R9 out of range cfg read", 64'(v), 64'h0);
    wr(2'd1, 20, 32'h1234);
    chk("R9 no flush out of range addr", 64'(flush), 64'd0);
    rd(2'd1, 20, v); chk("R9 out of range addr read", 64'(v), 64'h0);

    // R5 bypass, R7 positive
    do_reset();
    wr(2'd2, 0, 32'h4);
    rd(2'd2, 0, v); chk("R7 bypass set with no lock", 64'(v), 64'h4);
    chk("R11 no flush on bypass-only change", 64'(flush), 64'd0);
    wr(2'd0, 0, 32'h00008900);
    wr(2'd1, 0, 32'h55);
    rd(2'd1, 0, v); chk("R5 addr stored despite locked TOR", 64'(v), 64'h55);
    wr(2'd1, 1, 32'h66);
    rd(2'd1, 1, v); chk("R5 locked entry addr stored", 64'(v), 64'h66);
    wr(2'd0, 0, 32'h0);
    rd(2'd0, 0, v); chk("R5 locked byte rewritten", 64'(v), 64'h0);
    wr(2'd0, 0, 32'h00008000);
    wr(2'd2, 0, 32'h0);
    wr(2'd2, 0, 32'h4);
    rd(2'd2, 0, v); chk("R7 bypass re-set refused", 64'(v), 64'h0);

    // R6, R8 lockdown
    do_reset();
    wr(2'd2, 0, 32'h3);
    chk("R11 flush on lockdown set", 64'(flush), 64'd1);
    wr(2'd2, 0, 32'h0);
    chk("R11 no flush when sticky", 64'(flush), 64'd0);
    rd(2'd2, 0, v); chk("R8 sticky bits", 64'(v), 64'h3);
    wr(2'd0, 0, 32'h05830686);
    rd(2'd0, 0, v); chk("R6 lockdown value rule", 64'(v), 64'h05830000);
    wr(2'd0, 0, 32'h05810686);
    rd(2'd0, 0, v); chk("R6 locked entry rewritten", 64'(v), 64'h05810000);
    chk("R10 count zero", 64'(rule_count), 64'd0);

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule